// File: doc/BRIEF.md
# Color Subcarrier Phase Synthesizer

This block generates the color subcarrier phase for a composite video encoder. A 32-bit phase accumulator runs on the 27 MHz pixel clock and adds a programmable increment every cycle, so the subcarrier frequency is as accurate as that clock. The top ten bits of the accumulator, plus a ten-bit hue offset, form the phase word that a downstream sine table and chroma modulator use.

The accumulator is cleared at the start of every line or at the start of every frame, which keeps the burst phase repeatable. After each line sync edge the block opens a burst window that lasts a fixed number of subcarrier periods. Inside the window it outputs the programmed burst amplitude. It also outputs a burst phase word that includes the reference angle of the selected standard. For 525-line operation the burst sits half a turn from the B-Y axis. For 625-line operation the burst alternates between +135 and -135 degrees from the U axis on successive lines.

A host writes the settings through a byte-wide write port. The increment and the hue are each held in shadow bytes until their last byte arrives, so the accumulator never runs on a half-written value.

Top module: `sc_synth`

## Requirements
- R1: Reset is synchronous and active-high. After reset all outputs are zero and the active increment is the `RESET_INC` parameter (default 0x21F07C1F). After reset is released, the second clock edge shows `phase_out` equal to the top ten bits of that increment (0x087 with the default).
- R2: Every clock edge without a clear adds the active increment to the accumulator, modulo 2^32. `phase_out` equals the accumulator's top ten bits plus the active hue, modulo 1024, as the accumulator stood one edge earlier.
- R3: The increment bytes sit at addresses 0x11 (bits 7:0), 0x12, 0x13 and 0x14 (bits 31:24). Writes to 0x11 to 0x13 only fill shadow bytes and leave the running frequency unchanged. A write to 0x14 loads all 32 bits at once, and the accumulator uses the new value from the next edge.
- R4: The hue's low byte is written at 0x15 and only held in a shadow byte. A write to 0x16 takes `wr_data[1:0]` as hue bits 9:8 and makes the full ten-bit hue active at once.
- R5: With `frame_mode` low, a falling edge on `hsync_n` clears the accumulator. Two edges after the low sample, `phase_out` equals the hue.
- R6: With `frame_mode` high, only a falling edge on `vsync_n` clears the accumulator, and a line sync edge leaves the phase running.
- R7: On the edge that samples a falling `hsync_n`, `burst_gate` rises. It falls on the edge of the ninth accumulator carry after that.
- R8: Address 0x10 holds the burst amplitude. `burst_amp` shows the amplitude on exactly the cycles where `burst_gate` is high, and is zero otherwise.
- R9: `burst_phase` equals `phase_out` plus a reference of 512 when `std_pal` is low. When `std_pal` is high the reference is 384 or 640. A line sign bit picks between them: 384 when it is clear, 640 when it is set. The bit is clear after reset and toggles on every falling `hsync_n`.
- R10: Writes to any address outside 0x10 to 0x16 change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write address |
| wr_data | input | 8 | Host write data |
| hsync_n | input | 1 | Line sync, active low |
| vsync_n | input | 1 | Field/frame sync, active low |
| std_pal | input | 1 | 1 selects the 625-line burst reference, 0 the 525-line one |
| frame_mode | input | 1 | 1 clears the accumulator per frame, 0 per line |
| phase_out | output | 10 | Subcarrier phase with hue applied |
| burst_phase | output | 10 | Phase plus the standard's burst reference |
| burst_gate | output | 1 | Burst window |
| burst_amp | output | 8 | Burst amplitude inside the window, else zero |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator, a 10-bit phase, a nine-period burst window and the 525-line reset increment. The reset increment makes the first carries appear within about eight clocks. Table entries with increments of one half and one quarter turn force a carry every second or fourth clock, so the nine-carry window closes within a short line. An all-ones increment exercises the modulo wrap at the top of the 32-bit range, and a full-scale hue exercises the ten-bit wrap of the phase adder.

// File: rtl/sc_pkg.sv
package sc_pkg;

  // host address map
  localparam logic [7:0] ADDR_AMP      = 8'h10;
  localparam logic [7:0] ADDR_INC_BASE = 8'h11;

  // burst reference in eighths of a turn
  function automatic logic [2:0] burst_eighths(input logic pal, input logic vneg);
    if (!pal) return 3'd4;
    return vneg ? 3'd5 : 3'd3;
  endfunction

endpackage

// File: rtl/sc_regs.sv
module sc_regs #(
  parameter int ACC_W     = 32,
  parameter int PHASE_W   = 10,
  parameter logic [ACC_W-1:0] RESET_INC = 32'h21F07C1F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  output logic [ACC_W-1:0]   inc_q,
  output logic [PHASE_W-1:0] hue_q,
  output logic [7:0]         amp_q
);
  import sc_pkg::*;

  localparam int NB = ACC_W / 8;
  localparam logic [7:0] ADDR_INC_TOP = ADDR_INC_BASE + 8'(NB - 1);
  localparam logic [7:0] ADDR_HUE_LO  = ADDR_INC_BASE + 8'(NB);
  localparam logic [7:0] ADDR_HUE_HI  = ADDR_INC_BASE + 8'(NB + 1);

  logic [ACC_W-9:0] shadow_w;
  logic [7:0]       hue_lo_q;

  genvar gi;
  generate
    for (gi = 0; gi < NB - 1; gi++) begin : g_shadow
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
        if (rst)
          byte_q <= '0;
        else if (wr_en && wr_addr == ADDR_INC_BASE + 8'(gi))
          byte_q <= wr_data;
      end
      assign shadow_w[gi*8 +: 8] = byte_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q    <= RESET_INC;
      hue_q    <= '0;
      hue_lo_q <= '0;
      amp_q    <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_AMP)     amp_q    <= wr_data;
      if (wr_addr == ADDR_INC_TOP) inc_q    <= {wr_data, shadow_w};
      if (wr_addr == ADDR_HUE_LO)  hue_lo_q <= wr_data;
      if (wr_addr == ADDR_HUE_HI)  hue_q    <= {wr_data[PHASE_W-9:0], hue_lo_q};
    end
  end

endmodule

// File: rtl/sc_accum.sv
module sc_accum #(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ACC_W-1:0]   inc,
  input  logic [PHASE_W-1:0] hue,
  input  logic               hsync_n,
  input  logic               vsync_n,
  input  logic               frame_mode,
  output logic               hs_fall,
  output logic               wrap,
  output logic [PHASE_W-1:0] phase_next,
  output logic [PHASE_W-1:0] phase_q
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             hs_d, vs_d, vs_fall, clear;

  assign hs_fall    = hs_d & ~hsync_n;
  assign vs_fall    = vs_d & ~vsync_n;
  assign clear      = frame_mode ? vs_fall : hs_fall;
  assign sum        = {1'b0, acc_q} + {1'b0, inc};
  assign wrap       = sum[ACC_W] & ~clear;
  assign phase_next = acc_q[ACC_W-1 -: PHASE_W] + hue;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      hs_d    <= 1'b1;
      vs_d    <= 1'b1;
      phase_q <= '0;
    end else begin
      hs_d    <= hsync_n;
      vs_d    <= vsync_n;
      acc_q   <= clear ? '0 : sum[ACC_W-1:0];
      phase_q <= phase_next;
    end
  end

endmodule

// File: rtl/sc_burst.sv
module sc_burst #(
  parameter int PHASE_W      = 10,
  parameter int BURST_CYCLES = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hs_fall,
  input  logic               wrap,
  input  logic               std_pal,
  input  logic [7:0]         amp,
  input  logic [PHASE_W-1:0] phase_next,
  output logic               gate_q,
  output logic [7:0]         amp_out_q,
  output logic [PHASE_W-1:0] bphase_q
);
  import sc_pkg::*;

  localparam int CNT_W = $clog2(BURST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BURST_CYCLES - 1);

  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               gate_n, sign_q;
  logic [PHASE_W-1:0] ref_w;

  always_comb begin
    gate_n = gate_q;
    cnt_n  = cnt_q;
    if (hs_fall) begin
      gate_n = 1'b1;
      cnt_n  = '0;
    end else if (gate_q && wrap) begin
      if (cnt_q == LAST) gate_n = 1'b0;
      else               cnt_n  = cnt_q + 1'b1;
    end
  end

  assign ref_w = {burst_eighths(std_pal, sign_q), {(PHASE_W-3){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q    <= 1'b0;
      cnt_q     <= '0;
      sign_q    <= 1'b0;
      amp_out_q <= '0;
      bphase_q  <= '0;
    end else begin
      gate_q    <= gate_n;
      cnt_q     <= cnt_n;
      sign_q    <= sign_q ^ hs_fall;
      amp_out_q <= gate_n ? amp : 8'h00;
      bphase_q  <= phase_next + ref_w;
    end
  end

endmodule

// File: rtl/sc_synth.sv
module sc_synth #(
  parameter int ACC_W        = 32,
  parameter int PHASE_W      = 10,
  parameter int BURST_CYCLES = 9,
  parameter logic [ACC_W-1:0] RESET_INC = 32'h21F07C1F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [7:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               hsync_n,
  input  logic               vsync_n,
  input  logic               std_pal,
  input  logic               frame_mode,
  output logic [PHASE_W-1:0] phase_out,
  output logic [PHASE_W-1:0] burst_phase,
  output logic               burst_gate,
  output logic [7:0]         burst_amp
);

  logic [ACC_W-1:0]   inc_q;
  logic [PHASE_W-1:0] hue_q;
  logic [7:0]         amp_q;
  logic               hs_fall, wrap;
  logic [PHASE_W-1:0] phase_next;

  sc_regs #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .RESET_INC(RESET_INC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .inc_q(inc_q), .hue_q(hue_q), .amp_q(amp_q)
  );

  sc_accum #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_accum (
    .clk(clk), .rst(rst), .inc(inc_q), .hue(hue_q), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .frame_mode(frame_mode), .hs_fall(hs_fall), .wrap(wrap),
    .phase_next(phase_next), .phase_q(phase_out)
  );

  sc_burst #(.PHASE_W(PHASE_W), .BURST_CYCLES(BURST_CYCLES)) u_burst (
    .clk(clk), .rst(rst), .hs_fall(hs_fall), .wrap(wrap), .std_pal(std_pal),
    .amp(amp_q), .phase_next(phase_next), .gate_q(burst_gate),
    .amp_out_q(burst_amp), .bphase_q(burst_phase)
  );

endmodule

// File: rtl/sc_synth_chk.sv
module sc_synth_chk #(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [7:0]         wr_addr,
  input logic               hsync_n,
  input logic               std_pal,
  input logic               frame_mode,
  input logic [PHASE_W-1:0] phase_out,
  input logic [PHASE_W-1:0] burst_phase,
  input logic               burst_gate,
  input logic [7:0]         burst_amp,
  input logic [ACC_W-1:0]   inc_q,
  input logic [PHASE_W-1:0] hue_q
);
  import sc_pkg::*;

  localparam int NB = ACC_W / 8;
  localparam logic [7:0] ADDR_PART_TOP = ADDR_INC_BASE + 8'(NB - 2);
  localparam logic [7:0] ADDR_HUE_LO   = ADDR_INC_BASE + 8'(NB);
  localparam logic [PHASE_W-1:0] REF_N  = PHASE_W'(1) << (PHASE_W - 1);
  localparam logic [PHASE_W-1:0] REF_P3 = PHASE_W'(3) << (PHASE_W - 3);
  localparam logic [PHASE_W-1:0] REF_P5 = PHASE_W'(5) << (PHASE_W - 3);

  logic live;
  logic [PHASE_W-1:0] diff;
  always_ff @(posedge clk) live <= !rst;
  assign diff = burst_phase - phase_out;

  // R8
  p_amp_gate_r8: assert property (@(posedge clk) disable iff (rst)
    live && !burst_gate |-> burst_amp == 8'h00);

  // R9
  p_ntsc_ref_r9: assert property (@(posedge clk) disable iff (rst)
    live && !$past(std_pal) |-> diff == REF_N);

  p_pal_ref_r9: assert property (@(posedge clk) disable iff (rst)
    live && $past(std_pal) |-> (diff == REF_P3 || diff == REF_P5));

  // R7
  p_gate_rise_r7: assert property (@(posedge clk) disable iff (rst)
    live && $fell(hsync_n) |=> burst_gate);

  // R3
  p_inc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_addr >= ADDR_INC_BASE && wr_addr <= ADDR_PART_TOP |=> $stable(inc_q));

  // R4
  p_hue_hold_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_addr == ADDR_HUE_LO |=> $stable(hue_q));

  // R5
  p_line_clear_r5: assert property (@(posedge clk) disable iff (rst)
    live && $fell(hsync_n) && !frame_mode |=> ##1 phase_out == $past(hue_q));

endmodule

bind sc_synth sc_synth_chk #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .hsync_n(hsync_n),
  .std_pal(std_pal), .frame_mode(frame_mode), .phase_out(phase_out),
  .burst_phase(burst_phase), .burst_gate(burst_gate), .burst_amp(burst_amp),
  .inc_q(inc_q), .hue_q(hue_q)
);

// File: tb/tb_sc_synth.sv
module tb_sc_synth;
  localparam int CLK_PERIOD = 10;
  localparam int BURST = 9;
  localparam logic [31:0] RST_INC = 32'h21F07C1F;

  // {inc[31:0], hue[9:0], pal, frame}
  localparam logic [43:0] VEC [5] = '{
    {32'h21F07C1F, 10'h000, 1'b0, 1'b0},
    {32'h2A098ACB, 10'h0C0, 1'b1, 1'b0},
    {32'h80000000, 10'h3FF, 1'b0, 1'b0},
    {32'h40000000, 10'h155, 1'b1, 1'b1},
    {32'hFFFFFFFF, 10'h001, 1'b0, 1'b0}
  };

  logic clk = 0, rst = 1, wr_en = 0, hsync_n = 1, vsync_n = 1, std_pal = 0, frame_mode = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [9:0] phase_out, burst_phase;
  logic burst_gate;
  logic [7:0] burst_amp;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string ctx = "R1";

  sc_synth dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .std_pal(std_pal), .frame_mode(frame_mode),
    .phase_out(phase_out), .burst_phase(burst_phase), .burst_gate(burst_gate),
    .burst_amp(burst_amp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model built from the requirements
  logic [31:0] m_acc, m_inc;
  logic [23:0] m_sh;
  logic [9:0]  m_hue, e_phase, e_bph;
  logic [7:0]  m_hlo, m_amp, e_amp;
  logic        m_sign, m_gate, m_hs, m_vs, e_gate;
  int          m_cnt;

  always @(posedge clk) begin
    logic hf, vf, clr, wrp, gn;
    logic [32:0] sum;
    logic [9:0] ph;
    if (rst) begin
      m_acc = 0; m_inc = RST_INC; m_sh = 0; m_hue = 0; m_hlo = 0; m_amp = 0;
      m_sign = 0; m_gate = 0; m_cnt = 0; m_hs = 1; m_vs = 1;
      e_phase = 0; e_bph = 0; e_gate = 0; e_amp = 0;
    end else begin
      hf  = m_hs & ~hsync_n;
      vf  = m_vs & ~vsync_n;
      clr = frame_mode ? vf : hf;
      sum = {1'b0, m_acc} + {1'b0, m_inc};
      wrp = sum[32] & ~clr;
      ph  = m_acc[31:22] + m_hue;
      e_phase = ph;
      e_bph   = ph + (std_pal ? (m_sign ? 10'd640 : 10'd384) : 10'd512);
      gn = m_gate;
      if (hf) begin gn = 1; m_cnt = 0; end
      else if (m_gate && wrp) begin
        if (m_cnt == BURST - 1) gn = 0; else m_cnt = m_cnt + 1;
      end
      m_gate = gn;
      e_gate = gn;
      e_amp  = gn ? m_amp : 8'h00;
      m_sign = m_sign ^ hf;
      if (wr_en) begin
        case (wr_addr)
          8'h10: m_amp = wr_data;
          8'h11: m_sh[7:0] = wr_data;
          8'h12: m_sh[15:8] = wr_data;
          8'h13: m_sh[23:16] = wr_data;
          8'h14: m_inc = {wr_data, m_sh};
          8'h15: m_hlo = wr_data;
          8'h16: m_hue = {wr_data[1:0], m_hlo};
          default: ;
        endcase
      end
      m_acc = clr ? 32'h0 : sum[31:0];
      m_hs = hsync_n;
      m_vs = vsync_n;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    chk(ctx, 32'(phase_out), 32'(e_phase));
    chk("R9", 32'(burst_phase), 32'(e_bph));
    chk("R7", 32'(burst_gate), 32'(e_gate));
    chk("R8", 32'(burst_amp), 32'(e_amp));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic hpulse();
    hsync_n = 0; cyc(); cyc(); hsync_n = 1;
  endtask

  task automatic vpulse();
    vsync_n = 0; cyc(); vsync_n = 1;
  endtask

  initial begin
    int gate_len;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", 32'(phase_out), 0);
    chk("R1", 32'(burst_phase), 0);
    chk("R1", 32'(burst_gate), 0);
    chk("R1", 32'(burst_amp), 0);
    rst = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1", 32'(phase_out), 32'h087);
    ctx = "R2";
    run(20);

    // table walk
    for (int v = 0; v < 5; v++) begin
      logic [31:0] inc;
      logic [9:0] hue;
      inc = VEC[v][43:12];
      hue = VEC[v][11:2];
      std_pal = VEC[v][1];
      frame_mode = VEC[v][0];
      ctx = "R3";
      wr(8'h10, 8'h40 + 8'(v));
      wr(8'h11, inc[7:0]);
      wr(8'h12, inc[15:8]);
      wr(8'h13, inc[23:16]);
      wr(8'h14, inc[31:24]);
      ctx = "R4";
      wr(8'h15, hue[7:0]);
      wr(8'h16, {6'b0, hue[9:8]});
      ctx = frame_mode ? "R6" : "R5";
      hpulse(); run(90);
      hpulse(); run(90);
      vpulse(); run(30);
      ctx = "R2";
      run(10);
    end

    // R5 directed: line clear brings phase to hue
    std_pal = 0; frame_mode = 0;
    ctx = "R4";
    wr(8'h15, 8'h21); wr(8'h16, 8'h02);
    ctx = "R5";
    hsync_n = 0; cyc(); cyc();
    chk("R5", 32'(phase_out), 32'h221);
    hsync_n = 1;
    // R7 directed: window length with a quarter-turn increment
    ctx = "R3";
    wr(8'h11, 8'h00); wr(8'h12, 8'h00); wr(8'h13, 8'h00); wr(8'h14, 8'h40);
    ctx = "R7";
    hsync_n = 0; cyc(); hsync_n = 1;
    gate_len = 0;
    for (int i = 0; i < 60; i++) begin
      cyc();
      if (burst_gate) gate_len++;
    end
    chk("R7", 32'(gate_len), 32'(BURST * 4 - 1));

    // R3 directed: partial bytes leave the frequency alone
    ctx = "R3";
    wr(8'h11, 8'hAA); wr(8'h12, 8'hBB); wr(8'h13, 8'hCC);
    run(12);
    wr(8'h14, 8'h10);
    run(12);

    // R4 directed: low hue byte alone does nothing
    ctx = "R4";
    wr(8'h15, 8'h77);
    run(8);
    wr(8'h16, 8'h03);
    run(8);

    // R10: unmapped addresses
    ctx = "R10";
    wr(8'h0F, 8'hFF); wr(8'h17, 8'hFF); wr(8'h20, 8'h55); wr(8'hFF, 8'h01);
    hpulse(); run(40);

    // R6 directed: line edge does not clear in frame mode
    frame_mode = 1; ctx = "R6";
    hpulse(); run(20);
    vpulse(); run(20);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule